// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table that sits in physical memory. The walk begins when a caller asserts a request with a virtual address and an access type, read or write. The walker reads one top-level entry and then one second-level (leaf) entry, one read at a time, through a plain request/response memory read port. It ends with exactly one one-cycle pulse. That pulse is either a translation, carrying the physical address and the leaf's access rights, or a fault that is marked as a page fault or a protection fault. The walker never writes to the table.

The virtual address is split into three fields. Bits 31:22 index the top-level table, bits 21:12 index the second-level table, and bits 11:0 are the offset within a 4 KB page. Each table holds 1024 entries of 32 bits each. An entry is read from the address `table base + index * 4`. The top-level table base comes from the `ptbr` input and is captured when a request is accepted. Entry layout: bit 0 is valid, bit 1 allows reads, bit 2 allows writes, and bits 31:12 hold a frame number. In a top-level entry that frame number is the base of the second-level table, `{entry[31:12], 12'h000}`. In a leaf entry it is the physical frame. Bits 11:3 are ignored.

The controller is a state machine with seven states. IDLE waits for a request. RD_TOP drives the top-level read for one cycle. WT_TOP waits for its response. RD_LEAF drives the leaf read for one cycle. WT_LEAF waits for the leaf response. DONE gives the translation pulse and FAULT gives the fault pulse. The transitions are as follows:
- IDLE goes to RD_TOP when a request is seen.
- RD_TOP always goes to WT_TOP.
- WT_TOP goes to FAULT on an invalid entry, or to RD_LEAF on a valid one.
- RD_LEAF always goes to WT_LEAF.
- WT_LEAF goes to FAULT on an invalid entry or a rights violation, or to DONE otherwise.
- DONE and FAULT both return to IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset `busy`, `mem_req`, `done` and `fault` are low, and `paddr` and `rights` are zero.
- R2: A request is accepted only when `busy` is low. A `req_valid` seen while `busy` is high is ignored: it starts no memory read, changes no result, and starts no later walk.
- R3: `busy` rises in the cycle after a request is accepted. It stays high up to and including the cycle of the `done` or `fault` pulse, and is low in the cycle after that pulse.
- R4: The first read is a one-cycle `mem_req` with `mem_addr = ptbr + vaddr[31:22] * 4`, using the `ptbr` value seen at acceptance.
- R5: After a valid top-level entry E, the second read has `mem_addr = {E[31:12], 12'h000} + vaddr[21:12] * 4`.
- R6: A top-level entry with bit 0 clear ends the walk with `fault` high and `fault_prot` low (page fault). No second memory read is issued.
- R7: A leaf with bit 0 clear gives a page fault (`fault_prot` low), whatever its rights bits are.
- R8: A valid leaf gives a protection fault (`fault`=1, `fault_prot`=1) in two cases: a write when bit 2 is clear, or a read when bit 1 is clear.
- R9: Otherwise `done` pulses with `paddr = {leaf[31:12], vaddr[11:0]}` and `rights = {leaf[2], leaf[1]}` (write, read). Outside a `done` pulse, `paddr` and `rights` are zero.
- R10: `done` and `fault` are never high together, and each is high for exactly one cycle per walk.
- R11: The walker waits any number of cycles for `mem_rsp_valid`. Responses that arrive while no read is outstanding are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access type: 1 for write, 0 for read |
| ptbr | input | 32 | Physical base address of the top-level table |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Physical address of the entry being read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Entry that was read |
| done | output | 1 | Translation pulse |
| fault | output | 1 | Fault pulse |
| fault_prot | output | 1 | During a fault: 1 for a protection fault, 0 for a page fault |
| paddr | output | 32 | Translated physical address, valid during `done` |
| rights | output | 2 | Leaf rights {write, read}, valid during `done` |

## Verification
Two decisions can land in the same cycle.

The first is a new request arriving in the very cycle the result pulse appears. The bench keeps `req_valid` high, with a changed address, from acceptance through the `done` cycle. It then checks three things: the scoreboard result is unchanged, the read count is unchanged, and `busy` stays low afterwards, so the overlapping request was dropped.

The second is the valid-bit check and the rights check deciding on the same leaf response. A leaf that is invalid but carries both rights bits is walked with a write, and the expected outcome is a page fault, not a protection fault.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_TOP,
        S_WT_TOP,
        S_RD_LEAF,
        S_WT_LEAF,
        S_DONE,
        S_FAULT
    } walk_state_e;

    // bit positions inside a table entry
    localparam int E_VALID = 0;
    localparam int E_READ  = 1;
    localparam int E_WRITE = 2;

    localparam int LEVELS = 2;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int PA_W   = 32,
    parameter int IDX_W  = 10,
    parameter int ENT_LG = 2
) (
    input  logic [PA_W-1:0]  base,
    input  logic [IDX_W-1:0] idx,
    output logic [PA_W-1:0]  addr
);
    localparam int PAD_W = PA_W - IDX_W - ENT_LG;

    assign addr = base + {{PAD_W{1'b0}}, idx, {ENT_LG{1'b0}}};
endmodule

// File: rtl/pt_leaf_check.sv
module pt_leaf_check (
    input  logic       ent_valid,
    input  logic       ent_read,
    input  logic       ent_write,
    input  logic       is_write,
    output logic       page_flt,
    output logic       prot_flt
);
    always_comb begin
        page_flt = !ent_valid;
        prot_flt = ent_valid && (is_write ? !ent_write : !ent_read);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter  int IDX_W  = 10,
    parameter  int OFF_W  = 12,
    parameter  int ENT_LG = 2,
    localparam int VA_W   = 2 * IDX_W + OFF_W,
    localparam int ENT_W  = 8 << ENT_LG,
    localparam int PA_W   = ENT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic [PA_W-1:0]  ptbr,
    output logic             busy,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data,
    output logic             done,
    output logic             fault,
    output logic             fault_prot,
    output logic [PA_W-1:0]  paddr,
    output logic [1:0]       rights
);
    localparam int FRM_W = PA_W - OFF_W;

    walk_state_e state_q, state_d;

    logic [VA_W-1:0] vaddr_q;
    logic            write_q;
    logic [PA_W-1:0] ptbr_q;
    logic [PA_W-1:0] tbl_q;
    logic [PA_W-1:0] paddr_q;
    logic [1:0]      rights_q;
    logic            prot_q;

    logic [PA_W-1:0] lvl_base [LEVELS];
    logic [PA_W-1:0] lvl_addr [LEVELS];

    logic leaf_page, leaf_prot;
    logic unused_rsv;

    assign unused_rsv = ^mem_rsp_data[OFF_W-1:E_WRITE+1];

    // one entry-address adder per table level
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        if (lv == 0) begin : g_top
            assign lvl_base[lv] = ptbr_q;
        end else begin : g_low
            assign lvl_base[lv] = tbl_q;
        end
        pt_entry_addr #(
            .PA_W  (PA_W),
            .IDX_W (IDX_W),
            .ENT_LG(ENT_LG)
        ) u_ea (
            .base(lvl_base[lv]),
            .idx (vaddr_q[OFF_W + (LEVELS-1-lv)*IDX_W +: IDX_W]),
            .addr(lvl_addr[lv])
        );
    end

    pt_leaf_check u_leaf (
        .ent_valid(mem_rsp_data[E_VALID]),
        .ent_read (mem_rsp_data[E_READ]),
        .ent_write(mem_rsp_data[E_WRITE]),
        .is_write (write_q),
        .page_flt (leaf_page),
        .prot_flt (leaf_prot)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_d = S_RD_TOP;
            S_RD_TOP:  state_d = S_WT_TOP;
            S_WT_TOP:  if (mem_rsp_valid)
                           state_d = mem_rsp_data[E_VALID] ? S_RD_LEAF : S_FAULT;
            S_RD_LEAF: state_d = S_WT_LEAF;
            S_WT_LEAF: if (mem_rsp_valid)
                           state_d = (leaf_page || leaf_prot) ? S_FAULT : S_DONE;
            S_DONE:    state_d = S_IDLE;
            S_FAULT:   state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            vaddr_q  <= '0;
            write_q  <= 1'b0;
            ptbr_q   <= '0;
            tbl_q    <= '0;
            paddr_q  <= '0;
            rights_q <= '0;
            prot_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid) begin
                vaddr_q <= req_vaddr;
                write_q <= req_write;
                ptbr_q  <= ptbr;
            end
            if (state_q == S_WT_TOP && mem_rsp_valid) begin
                tbl_q   <= {mem_rsp_data[ENT_W-1:OFF_W], {OFF_W{1'b0}}};
                prot_q  <= 1'b0;
                paddr_q <= '0;
                rights_q <= '0;
            end
            if (state_q == S_WT_LEAF && mem_rsp_valid) begin
                prot_q <= leaf_prot;
                if (leaf_page || leaf_prot) begin
                    paddr_q  <= '0;
                    rights_q <= '0;
                end else begin
                    paddr_q  <= {mem_rsp_data[ENT_W-1 -: FRM_W], vaddr_q[OFF_W-1:0]};
                    rights_q <= {mem_rsp_data[E_WRITE], mem_rsp_data[E_READ]};
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        mem_req    = (state_q == S_RD_TOP) || (state_q == S_RD_LEAF);
        mem_addr   = (state_q == S_RD_LEAF) ? lvl_addr[1] : lvl_addr[0];
        done       = (state_q == S_DONE);
        fault      = (state_q == S_FAULT);
        fault_prot = fault && prot_q;
        paddr      = done ? paddr_q  : '0;
        rights     = done ? rights_q : '0;
    end

endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int VA_W  = 32,
    parameter int PA_W  = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic [PA_W-1:0] ptbr,
    input logic            busy,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            done,
    input logic            fault,
    input logic [PA_W-1:0] paddr
);
    localparam int PAD_W = PA_W - IDX_W - 2;

    logic [VA_W-1:0] va_c;
    logic [PA_W-1:0] base_c;
    logic [1:0]      rd_n;
    logic            unused_c;

    assign unused_c = ^{va_c[OFF_W+IDX_W-1:OFF_W], paddr[PA_W-1:OFF_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_c   <= '0;
            base_c <= '0;
            rd_n   <= '0;
        end else if (req_valid && !busy) begin
            va_c   <= req_vaddr;
            base_c <= ptbr;
            rd_n   <= '0;
        end else if (mem_req && rd_n != 2'd3) begin
            rd_n <= rd_n + 2'd1;
        end
    end

    p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !fault) |=> busy);

    p_drop_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !busy);

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !(done || fault));

    p_req_in_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_one_cycle_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_top_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && rd_n == 2'd0) |->
        mem_addr == base_c + {{PAD_W{1'b0}}, va_c[VA_W-1 -: IDX_W], 2'b00});

    p_two_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> rd_n < 2'd2);

    p_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> paddr[OFF_W-1:0] == va_c[OFF_W-1:0]);

endmodule

bind pt_walker pt_walker_checker #(
    .IDX_W(IDX_W),
    .OFF_W(OFF_W),
    .VA_W (VA_W),
    .PA_W (PA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_vaddr(req_vaddr),
    .ptbr     (ptbr),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .done     (done),
    .fault    (fault),
    .paddr    (paddr)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] ptbr = 32'h0001_0000;
    logic        busy, mem_req, done, fault, fault_prot;
    logic [31:0] mem_addr, paddr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [1:0]  rights;

    always #10 clk = ~clk;   // 50 MHz

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .ptbr(ptbr), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
        .fault_prot(fault_prot), .paddr(paddr), .rights(rights)
    );

    typedef struct {
        logic        flt;
        logic        prot;
        logic [31:0] pa;
        logic [1:0]  rt;
        int          reads;
        logic [31:0] a1;
        logic [31:0] a2;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic [31:0] pmem [logic [31:0]];
    logic [31:0] rd_log [4];
    int rd_cnt = 0;
    int lat = 1;
    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input logic [31:0] a);
        if (pmem.exists(a)) return pmem[a];
        return 32'h0;
    endfunction

    function automatic logic [31:0] va(input int t, input int l, input int off);
        return {t[9:0], l[9:0], off[11:0]};
    endfunction

    // memory responder (R11: latency set by lat)
    logic [31:0] pend;
    int cd = 0;
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pend;
                end
            end
            if (mem_req) begin
                if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
                rd_cnt++;
                pend = mread(mem_addr);
                cd = lat;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (done || fault)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected result", {31'b0, done}, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(busy, "R3", "busy at pulse", {31'b0, busy}, 32'h1);
                    check(fault == e.flt && done == !e.flt, e.tag, "fault",
                          {31'b0, fault}, {31'b0, e.flt});
                    check(fault_prot == e.prot, e.tag, "fault_prot",
                          {31'b0, fault_prot}, {31'b0, e.prot});
                    check(paddr == e.pa, e.tag, "paddr", paddr, e.pa);
                    check(rights == e.rt, e.tag, "rights", {30'b0, rights}, {30'b0, e.rt});
                    check(rd_cnt == e.reads, e.reads == 1 ? "R6" : "R5", "read count",
                          rd_cnt, e.reads);
                    check(rd_log[0] == e.a1, "R4", "top read addr", rd_log[0], e.a1);
                    if (e.reads == 2)
                        check(rd_log[1] == e.a2, "R5", "leaf read addr", rd_log[1], e.a2);
                end
            end
        end
    end

    task automatic walk(input logic [31:0] v, input logic wr, input bit hold);
        exp_t e;
        logic [31:0] t, l;
        @(negedge clk);
        e.a1 = ptbr + {20'b0, v[31:22], 2'b00};
        e.a2 = 32'h0; e.pa = 32'h0; e.rt = 2'b00; e.prot = 1'b0;
        t = mread(e.a1);
        if (!t[0]) begin
            e.flt = 1'b1; e.reads = 1; e.tag = "R6";
        end else begin
            e.reads = 2;
            e.a2 = {t[31:12], 12'h0} + {20'b0, v[21:12], 2'b00};
            l = mread(e.a2);
            if (!l[0]) begin
                e.flt = 1'b1; e.tag = "R7";
            end else if (wr ? !l[2] : !l[1]) begin
                e.flt = 1'b1; e.prot = 1'b1; e.tag = "R8";
            end else begin
                e.flt = 1'b0; e.tag = "R9";
                e.pa = {l[31:12], v[11:0]}; e.rt = {l[2], l[1]};
            end
        end
        exp_q.push_back(e);
        rd_cnt = 0;
        req_vaddr = v; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        check(busy, "R3", "busy after accept", {31'b0, busy}, 32'h1);
        if (!hold) req_valid = 1'b0;
        else begin req_vaddr = ~v; req_write = ~wr; end   // R2: ignored while busy
        while (!(done || fault)) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!busy && !done && !fault, "R3", "idle after pulse",
              {29'b0, busy, done, fault}, 32'h0);
        @(negedge clk);
        check(!busy, "R2", "no extra walk", {31'b0, busy}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        pmem[32'h0001_0004] = 32'h0002_0001;   // top idx 1 -> table 0x20000
        pmem[32'h0001_000C] = 32'h0003_0001;   // top idx 3 -> empty table
        pmem[32'h0001_0FFC] = 32'h0004_0001;   // top idx 1023
        pmem[32'h0001_0008] = 32'h0000_0006;   // top idx 2 invalid (rights set)
        pmem[32'h0002_0000] = 32'hABCD_E007;   // RW
        pmem[32'h0002_0014] = 32'h1234_5003;   // read-only
        pmem[32'h0002_0018] = 32'h5432_1005;   // write-only
        pmem[32'h0002_001C] = 32'h0000_0006;   // invalid, rights set
        pmem[32'h0002_0FFC] = 32'hFFFF_F007;
        pmem[32'h0004_0FFC] = 32'h0000_1003;

        repeat (3) @(negedge clk);
        check(!busy && !mem_req && !done && !fault && paddr == 0 && rights == 0,
              "R1", "reset state", {27'b0, busy, mem_req, done, fault, |rights}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: stray response while idle is ignored
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_FFFF;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        @(negedge clk);
        check(!busy && !done && !fault, "R11", "stray response",
              {29'b0, busy, done, fault}, 32'h0);

        lat = 1; walk(va(1, 0, 12'h123), 1'b0, 1'b0);      // R9
        lat = 3; walk(va(1, 0, 12'hABC), 1'b1, 1'b0);      // R9, R11
        lat = 2; walk(va(1, 5, 12'h010), 1'b0, 1'b0);      // R9 read-only read
        lat = 5; walk(va(1, 5, 12'h010), 1'b1, 1'b0);      // R8 write to read-only
        lat = 1; walk(va(1, 6, 12'h001), 1'b0, 1'b0);      // R8 read of write-only
        walk(va(1, 6, 12'h002), 1'b1, 1'b0);               // R9
        lat = 4; walk(va(2, 9, 12'h000), 1'b1, 1'b0);      // R6
        walk(va(0, 0, 12'h000), 1'b0, 1'b0);               // R6 index 0
        lat = 2; walk(va(1, 7, 12'h444), 1'b1, 1'b0);      // R7 priority over rights
        walk(va(3, 1, 12'h555), 1'b0, 1'b0);               // R7
        lat = 1; walk(va(1023, 1023, 12'hFFF), 1'b0, 1'b0);// R9 boundary
        walk(va(1, 1023, 12'h000), 1'b1, 1'b0);            // R9
        lat = 3; walk(va(1, 0, 12'h777), 1'b1, 1'b1);      // R2 overlap with pulse
        walk(va(2, 0, 12'h000), 1'b0, 1'b1);               // R2 overlap with fault
        ptbr = 32'h0003_0000;
        lat = 1; walk(va(0, 0, 12'h000), 1'b0, 1'b0);      // R4 new base, empty -> R6

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10", "all results seen", exp_q.size(), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule